// File: doc/BRIEF.md
# Floating-Point Sign-Injection and Writeback Unit

This block is the last stage of a floating-point pipeline. It carries out the bit-level operations itself: copying, inverting or xoring a sign bit onto another operand, and the raw bit moves between the integer and floating-point register files. For all other operations it passes through the 32-bit result that an external arithmetic unit supplies. Every single-precision value bound for the floating-point file is placed in a register `FLEN` bits wide. When `FLEN` is 64, the upper half of that register is filled with ones. Integer-bound values are sign- or zero-extended to `XLEN`.

The unit also holds the 32-bit floating-point control/status word. Only its low five bits, the exception flags, respond to the arithmetic unit. Flags are accumulated: each new set of flags is ORed into the old ones. Software can replace the whole word through a dedicated write port. Write data and write enables are combinational from the inputs of the current cycle. The status word is registered.

Top module: `fp_wb_unit`

## Requirements
- R1: Operation code 0 (plain sign injection) writes `{opb[31], opa[30:0]}` as the single-precision result.
- R2: Operation code 1 (negated sign injection) writes `{~opb[31], opa[30:0]}`.
- R3: Operation code 2 (xor sign injection) writes `opa` with bit 31 replaced by `opa[31] ^ opb[31]`.
- R4: Every floating-point write carries the 32-bit result in bits [31:0]. With `FLEN` = 64, bits [63:32] are all ones. With `FLEN` = 32, the result is written unchanged.
- R5: Operation code 3 (float to integer move) writes `opa` sign-extended to `XLEN`. Operation code 4 (integer to float move) writes `int_src[31:0]` to the floating-point file, boxed as in R4.
- R6: Codes 5 (arithmetic), 6 (min/max) and 10 (integer to float conversion) write `au_res` to the floating-point file. Code 8 (signed conversion to integer) writes `au_res` sign-extended to the integer file. Codes 9 (unsigned conversion), 7 (compare) and 11 (classify) write it zero-extended.
- R7: On a strobed operation with code 5, 6, 7, 8 or 9, the unit ORs `au_flags` into status bits [4:0] at the next clock edge. A flag, once set, remains set.
- R8: Codes 0–4, 10, 11 and the unused codes 12–15 leave the status word unchanged.
- R9: A flag update never changes status bits [31:5].
- R10: A software write replaces the whole status word at the next edge. It takes priority over a flag update in the same cycle.
- R11: Reset clears the status word to zero.
- R12: `fp_we` is high only for strobed codes 0, 1, 2, 4, 5, 6 and 10. `int_we` is high only for strobed codes 3, 7, 8, 9 and 11. Unused codes raise neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Writeback strobe for the current operation |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First floating-point operand |
| opb_i | input | 32 | Second floating-point operand (sign source) |
| int_src_i | input | XLEN | Integer source for the move into the floating-point file |
| au_res_i | input | 32 | Result from the arithmetic unit |
| au_flags_i | input | 5 | Exception flags from the arithmetic unit |
| sw_wr_i | input | 1 | Software write of the status word |
| sw_data_i | input | 32 | Software write data |
| fp_we_o | output | 1 | Floating-point register write enable |
| fp_wdata_o | output | FLEN | Floating-point register write data |
| int_we_o | output | 1 | Integer register write enable |
| int_wdata_o | output | XLEN | Integer register write data |
| fcsr_o | output | 32 | Current status word |

## Verification
The three sign-injection codes and the two moves are swept over a set of spread operand patterns under every combination of the two sign bits. This distinguishes copying, inverting and xoring the sign, and it would expose any leakage of `opb` magnitude bits. Arithmetic results with bit 31 set and with bit 31 clear show whether sign extension or zero extension was applied on each integer path. Every flag pattern is applied over a status word whose upper bits are set, which detects a lost accumulation or damage to the upper bits. Non-flag codes, unused codes, and simultaneous software and flag writes each check one priority or no-effect case.

// File: rtl/fpwb_pkg.sv
package fpwb_pkg;
  localparam int FLAG_W = 5;
  localparam int CSR_W  = 32;
  localparam int SP_W   = 32;

  typedef enum logic [3:0] {
    OP_SGNJ   = 4'd0,
    OP_SGNJN  = 4'd1,
    OP_SGNJX  = 4'd2,
    OP_MV_F2X = 4'd3,
    OP_MV_X2F = 4'd4,
    OP_ARITH  = 4'd5,
    OP_MINMAX = 4'd6,
    OP_CMP    = 4'd7,
    OP_CVT_FS = 4'd8,
    OP_CVT_FU = 4'd9,
    OP_CVT_IF = 4'd10,
    OP_CLASS  = 4'd11
  } fpwb_op_e;

  function automatic logic raises_flags(input fpwb_op_e op);
    return (op == OP_ARITH) || (op == OP_MINMAX) || (op == OP_CMP) ||
           (op == OP_CVT_FS) || (op == OP_CVT_FU);
  endfunction
endpackage

// File: rtl/fpwb_sign_inj.sv
module fpwb_sign_inj
  import fpwb_pkg::*;
(
  input  logic [1:0]      mode_i,   // 0 copy, 1 invert, 2 xor
  input  logic [SP_W-1:0] mag_i,
  input  logic            sgn_i,
  output logic [SP_W-1:0] res_o
);
  logic new_sign;

  always_comb begin
    unique case (mode_i)
      2'd1:    new_sign = ~sgn_i;
      2'd2:    new_sign = mag_i[SP_W-1] ^ sgn_i;
      default: new_sign = sgn_i;
    endcase
    res_o = {new_sign, mag_i[SP_W-2:0]};
  end
endmodule

// File: rtl/fpwb_box.sv
module fpwb_box
  import fpwb_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [SP_W-1:0] val_i,
  output logic [FLEN-1:0] boxed_o
);
  localparam int PAD_W = FLEN - SP_W;

  generate
    if (PAD_W > 0) begin : g_box
      assign boxed_o = {{PAD_W{1'b1}}, val_i};
    end else begin : g_flat
      assign boxed_o = val_i;
    end
  endgenerate
endmodule

// File: rtl/fpwb_ext.sv
module fpwb_ext
  import fpwb_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [SP_W-1:0] val_i,
  input  logic            signed_i,
  output logic [XLEN-1:0] ext_o
);
  localparam int PAD_W = XLEN - SP_W;

  generate
    if (PAD_W > 0) begin : g_wide
      assign ext_o = {{PAD_W{signed_i & val_i[SP_W-1]}}, val_i};
    end else begin : g_same
      logic unused_sel;
      assign unused_sel = signed_i;
      assign ext_o      = val_i;
    end
  endgenerate
endmodule

// File: rtl/fpwb_csr.sv
module fpwb_csr
  import fpwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              sw_wr_i,
  input  logic [CSR_W-1:0]  sw_data_i,
  output logic [CSR_W-1:0]  csr_o
);
  logic [CSR_W-1:0] csr_q, csr_d;
  logic             csr_en;

  always_comb begin
    csr_en = sw_wr_i | upd_i;
    csr_d  = csr_q;
    if (sw_wr_i) begin
      csr_d = sw_data_i;
    end else if (upd_i) begin
      csr_d[FLAG_W-1:0] = csr_q[FLAG_W-1:0] | flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
    end else if (csr_en) begin
      csr_q <= csr_d;
    end
  end

  assign csr_o = csr_q;

  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> $stable(csr_q[CSR_W-1:FLAG_W])); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_i |=> ((csr_q[FLAG_W-1:0] & $past(csr_q[FLAG_W-1:0])) == $past(csr_q[FLAG_W-1:0]))); // R7
  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i |=> (csr_q == $past(sw_data_i))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && !upd_i) |=> $stable(csr_q)); // R8
endmodule

// File: rtl/fp_wb_unit.sv
module fp_wb_unit
  import fpwb_pkg::*;
#(
  parameter int FLEN = 64,
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        op_i,
  input  logic [31:0]       opa_i,
  input  logic [31:0]       opb_i,
  input  logic [XLEN-1:0]   int_src_i,
  input  logic [31:0]       au_res_i,
  input  logic [4:0]        au_flags_i,
  input  logic              sw_wr_i,
  input  logic [31:0]       sw_data_i,
  output logic              fp_we_o,
  output logic [FLEN-1:0]   fp_wdata_o,
  output logic              int_we_o,
  output logic [XLEN-1:0]   int_wdata_o,
  output logic [31:0]       fcsr_o
);
  fpwb_op_e        op;
  logic [SP_W-1:0] sj_res, fp_sp, int_sp;
  logic            fp_sel, int_sel, int_signed, flag_upd;
  logic [30:0]     unused_opb;

  assign op         = fpwb_op_e'(op_i);
  assign unused_opb = opb_i[30:0];

  generate
    if (XLEN > SP_W) begin : g_isrc_hi
      logic [XLEN-SP_W-1:0] unused_isrc;
      assign unused_isrc = int_src_i[XLEN-1:SP_W];
    end
  endgenerate

  fpwb_sign_inj u_sj (
    .mode_i (op_i[1:0]),
    .mag_i  (opa_i),
    .sgn_i  (opb_i[31]),
    .res_o  (sj_res)
  );

  always_comb begin
    fp_sel     = 1'b0;
    int_sel    = 1'b0;
    int_signed = 1'b0;
    fp_sp      = au_res_i;
    int_sp     = au_res_i;
    unique case (op)
      OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
        fp_sel = 1'b1;
        fp_sp  = sj_res;
      end
      OP_MV_X2F: begin
        fp_sel = 1'b1;
        fp_sp  = int_src_i[SP_W-1:0];
      end
      OP_ARITH, OP_MINMAX, OP_CVT_IF: fp_sel = 1'b1;
      OP_MV_F2X: begin
        int_sel    = 1'b1;
        int_signed = 1'b1;
        int_sp     = opa_i;
      end
      OP_CVT_FS: begin
        int_sel    = 1'b1;
        int_signed = 1'b1;
      end
      OP_CVT_FU, OP_CMP, OP_CLASS: int_sel = 1'b1;
      default: ;
    endcase
  end

  assign fp_we_o  = wr_en & fp_sel;
  assign int_we_o = wr_en & int_sel;
  assign flag_upd = wr_en & raises_flags(op);

  fpwb_box #(.FLEN(FLEN)) u_box (
    .val_i   (fp_sp),
    .boxed_o (fp_wdata_o)
  );

  fpwb_ext #(.XLEN(XLEN)) u_ext (
    .val_i    (int_sp),
    .signed_i (int_signed),
    .ext_o    (int_wdata_o)
  );

  fpwb_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (flag_upd),
    .flags_i   (au_flags_i),
    .sw_wr_i   (sw_wr_i),
    .sw_data_i (sw_data_i),
    .csr_o     (fcsr_o)
  );

  AST_SGNJ_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_i == 4'd0) |-> (fp_wdata_o[31:0] == {opb_i[31], opa_i[30:0]})); // R1
  AST_SGNJN_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_i == 4'd1) |-> (fp_wdata_o[31] != opb_i[31])); // R2
  AST_SGNJX_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_i == 4'd2) |-> (fp_wdata_o[31] == (opa_i[31] ^ opb_i[31]))); // R3
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(fp_we_o && int_we_o)); // R12
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (fcsr_o == '0)); // R11

  generate
    if (FLEN > SP_W) begin : g_box_chk
      AST_BOX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        fp_we_o |-> (&fp_wdata_o[FLEN-1:SP_W])); // R4
    end
    if (XLEN > SP_W) begin : g_ext_chk
      AST_MV_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_i == 4'd3) |-> (int_wdata_o[XLEN-1] == opa_i[31])); // R5
    end
  endgenerate
endmodule

// File: tb/sim_fp_wb_unit.sv
module sim_fp_wb_unit;
  localparam int FLEN = 64;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      op;
  logic [31:0]     opa, opb, au_res, sw_data;
  logic [XLEN-1:0] int_src;
  logic [4:0]      au_flags;
  logic            sw_wr;
  logic            fp_we, int_we;
  logic [FLEN-1:0] fp_wdata;
  logic [XLEN-1:0] int_wdata;
  logic [31:0]     fcsr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_csr;

  always #10 clk = ~clk;

  fp_wb_unit #(.FLEN(FLEN), .XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op_i(op), .opa_i(opa), .opb_i(opb),
    .int_src_i(int_src), .au_res_i(au_res), .au_flags_i(au_flags),
    .sw_wr_i(sw_wr), .sw_data_i(sw_data), .fp_we_o(fp_we), .fp_wdata_o(fp_wdata),
    .int_we_o(int_we), .int_wdata_o(int_wdata), .fcsr_o(fcsr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] box(input logic [31:0] v);
    return {32'hFFFF_FFFF, v};
  endfunction

  // one strobed operation: check comb outputs, then the registered status word
  task automatic run_op(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] res, input logic [4:0] flg,
                        input logic sw, input logic [31:0] swd, input logic en);
    logic [63:0] efp, eint;
    logic efw, eiw;
    @(negedge clk);
    wr_en = en; op = o; opa = a; opb = b; au_res = res; au_flags = flg;
    sw_wr = sw; sw_data = swd; int_src = {32'h5A5A_0F0F, a ^ 32'h1357_9BDF};
    efw = 1'b0; eiw = 1'b0; efp = '0; eint = '0;
    case (o)
      4'd0:  begin efw = 1; efp = box({b[31], a[30:0]}); end
      4'd1:  begin efw = 1; efp = box({~b[31], a[30:0]}); end
      4'd2:  begin efw = 1; efp = box({a[31] ^ b[31], a[30:0]}); end
      4'd3:  begin eiw = 1; eint = {{32{a[31]}}, a}; end
      4'd4:  begin efw = 1; efp = box(a ^ 32'h1357_9BDF); end
      4'd5, 4'd6, 4'd10: begin efw = 1; efp = box(res); end
      4'd8:  begin eiw = 1; eint = {{32{res[31]}}, res}; end
      4'd7, 4'd9, 4'd11: begin eiw = 1; eint = {32'h0, res}; end
      default: ;
    endcase
    efw &= en; eiw &= en;
    #2;
    check(fp_we == efw, "R12 fp_we", 64'(fp_we), 64'(efw));
    check(int_we == eiw, "R12 int_we", 64'(int_we), 64'(eiw));
    if (efw) begin
      if (o <= 4'd2) check(fp_wdata == efp, "R1/R2/R3 sign injection (R4 box)", fp_wdata, efp);
      else if (o == 4'd4) check(fp_wdata == efp, "R5 move to float (R4 box)", fp_wdata, efp);
      else check(fp_wdata == efp, "R6 fp result (R4 box)", fp_wdata, efp);
    end
    if (eiw) begin
      if (o == 4'd3) check(int_wdata == eint, "R5 move sign-extend", int_wdata, eint);
      else check(int_wdata == eint, "R6 int extension", int_wdata, eint);
    end
    if (sw) exp_csr = swd;
    else if (en && (o inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd9})) exp_csr[4:0] |= flg;
    @(posedge clk);
    #2;
    if (sw) check(fcsr == exp_csr, "R10 sw write wins", 64'(fcsr), 64'(exp_csr));
    else if (en && (o inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd9}))
      check(fcsr == exp_csr, "R7/R9 sticky flags", 64'(fcsr), 64'(exp_csr));
    else check(fcsr == exp_csr, "R8 status unchanged", 64'(fcsr), 64'(exp_csr));
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    rst_n = 1'b0; wr_en = 0; op = 0; opa = 0; opb = 0; au_res = 0; au_flags = 0;
    sw_wr = 0; sw_data = 0; int_src = '0; exp_csr = '0;
    repeat (3) @(posedge clk);
    #2 check(fcsr == 32'h0, "R11 reset clears status", 64'(fcsr), 64'h0);
    rst_n = 1'b1;

    // sign injection and moves: spread patterns x all sign combos
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 4; s++) begin
        a = (32'h9E37_79B9 * (i + 1)) ^ (32'h0000_FFFF << i);
        b = 32'h7F4A_7C15 * (i + 3);
        a[31] = s[0]; b[31] = s[1];
        for (int o = 0; o < 5; o++) run_op(4'(o), a, b, 32'h0, 5'h1F, 1'b0, 32'h0, 1'b1);
      end
    end

    // software write: set upper bits, clear flags
    run_op(4'd0, 32'h1, 32'h2, 32'h0, 5'h0, 1'b1, 32'hABCD_E0E0, 1'b1);

    // every flag pattern through every result op, positive and negative results
    for (int f = 0; f < 32; f++) begin
      for (int o = 5; o < 12; o++) begin
        run_op(4'(o), 32'h0, 32'h0, (f[0] ? 32'h8000_0000 : 32'h0) | 32'(f * 32'h0101_0103),
               5'(f), 1'b0, 32'h0, 1'b1);
      end
      if (f % 8 == 7) run_op(4'd0, 32'h0, 32'h0, 32'h0, 5'h0, 1'b1, 32'hFFFF_FFE0, 1'b1);
    end

    // unused codes and unstrobed flag ops: no writes, no status change (R8, R12)
    for (int o = 12; o < 16; o++) run_op(4'(o), 32'h8000_0001, 32'h8000_0000, 32'h1, 5'h1F, 1'b0, 32'h0, 1'b1);
    run_op(4'd5, 32'h0, 32'h0, 32'h3F80_0000, 5'h1F, 1'b0, 32'h0, 1'b0);

    // software write in the same cycle as a flag update (R10)
    run_op(4'd5, 32'h0, 32'h0, 32'h4000_0000, 5'h1F, 1'b1, 32'h0000_0102, 1'b1);
    run_op(4'd8, 32'h0, 32'h0, 32'hFFFF_FFFE, 5'h04, 1'b0, 32'h0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule